// File: doc/BRIEF.md
# Shared-Comparator Merge Tree Level

This block is one level of a streaming merge-sort tree. It accepts `2*NUM_PAIRS` sorted input streams and produces `NUM_PAIRS` sorted output streams. Output stream `i` merges input streams `2i` and `2i+1` into ascending key order. Each record is a key, a payload and an end-of-run flag. A run is a sorted group of records that ends with a record whose flag is set. The level merges run `k` of one input with run `k` of its partner.

All pairs share one comparator. A round-robin scheduler grants at most one pair per cycle, and only a pair whose needed inputs hold data and which holds an output credit. The grant then goes through a pipeline: it reads the heads, compares them and pops the smaller one, and writes it to the output queue. The write lands three cycles after the grant. The input queues of every stream share one storage array, addressed by `{queue, slot}`. The output queues share a second array. Each output queue has a credit counter. A credit is taken when the pair is granted and given back when the consumer takes a record. A granted pair is marked busy until its pop has happened, so a stale head can never be compared twice.

Each pair has a run-state machine with three states:
- `RUN_MERGE`: both inputs are inside their current run, so the two heads are compared.
- `RUN_ONLY_A`: input `2i+1` has ended its run, so the records of input `2i` pass through.
- `RUN_ONLY_B`: input `2i` has ended its run, so the records of input `2i+1` pass through.

The transitions are as follows:
- MERGE→ONLY_B: a popped record of input `2i` carries the end flag.
- MERGE→ONLY_A: a popped record of input `2i+1` carries the end flag.
- ONLY_A→MERGE and ONLY_B→MERGE: the passed-through input pops its end-flagged record. That record leaves with the output end flag set.

Top module: `mtl_merge_level`

## Requirements
- R1: Output stream i carries only records that entered on input streams 2i and 2i+1, each record exactly once, with key and payload unchanged.
- R2: Within one merged run the output keys never decrease. `out_last` is set only on the record that completes both input runs (the last of the two runs to be consumed).
- R3: When the two compared heads have equal keys, the record from input 2i leaves before the record from input 2i+1.
- R4: Once one input's end-flagged record has been consumed, the remaining records of the partner's current run leave next, in order. The ended input's next run has no effect on them, even when it holds smaller keys.
- R5: A pair is serviced only when it holds an output credit and every input it still needs is non-empty. In state MERGE, a pair with one empty input produces no output.
- R6: An output queue never holds more than `OUT_DEPTH` records. While `out_ready` is held low, the block stops accepting input (`in_ready` goes low once the input queues are full), and no record is lost.
- R7: After reset every `out_valid` is 0 and every `in_ready` is 1.
- R8: While `out_valid[i]` is 1 and `out_ready[i]` is 0, output i keeps its valid, key, payload and end flag unchanged into the next cycle.
- R9: A pair is never granted again before its previous grant has popped. At most one record leaves the input queues per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2*NUM_PAIRS | Per input stream: record offered |
| in_ready | output | 2*NUM_PAIRS | Per input stream: queue has room |
| in_last | input | 2*NUM_PAIRS | Per input stream: record ends its run |
| in_key | input | 2*NUM_PAIRS*KEY_W | Per input stream sort key, stream s at bits s*KEY_W |
| in_pay | input | 2*NUM_PAIRS*PAY_W | Per input stream payload, stream s at bits s*PAY_W |
| out_valid | output | NUM_PAIRS | Per output stream: head record present |
| out_ready | input | NUM_PAIRS | Per output stream: consumer takes the head |
| out_last | output | NUM_PAIRS | Per output stream: head ends a merged run |
| out_key | output | NUM_PAIRS*KEY_W | Per output stream head key |
| out_pay | output | NUM_PAIRS*PAY_W | Per output stream head payload |

## Verification
A single cycle can hold three events for the same queues: a consumer taking a record, which returns a credit, a grant consuming a credit, and an input pop together with an enqueue. If any counter update is lost in that cycle, records are duplicated or dropped. The bench provokes these overlaps by gating `in_valid` and `out_ready` with pseudo-random bits while streams are merged. Each output record is judged against a merge that the bench computes from the stimulus table, with payloads as unique tags. A held-low `out_ready` phase shows that credits stop the merge and that the input queues then refuse data.

// File: rtl/mtl_pkg.sv
package mtl_pkg;

    typedef enum logic [1:0] {
        RUN_MERGE  = 2'd0,
        RUN_ONLY_A = 2'd1,
        RUN_ONLY_B = 2'd2
    } run_state_e;

    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mtl_in_queues.sv
module mtl_in_queues
    import mtl_pkg::*;
#(
    parameter int unsigned NQ    = 4,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned REC_W = 17,
    localparam int unsigned QW   = idx_w(NQ),
    localparam int unsigned AW   = idx_w(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NQ-1:0]              enq_valid,
    input  logic [NQ-1:0][REC_W-1:0]   enq_rec,
    output logic [NQ-1:0]              enq_ready,
    input  logic                       pop_en,
    input  logic [QW-1:0]              pop_q,
    output logic [NQ-1:0][REC_W-1:0]   head_rec,
    output logic [NQ-1:0]              nonempty
);

    localparam int unsigned SLOTS = 1 << (QW + AW);

    logic [REC_W-1:0] mem [SLOTS];
    logic [AW-1:0]    wp  [NQ];
    logic [AW-1:0]    rp  [NQ];
    logic [CW-1:0]    cnt [NQ];
    logic [NQ-1:0]    enq_fire;
    logic [NQ-1:0]    pop_hit;

    always_comb begin
        for (int q = 0; q < int'(NQ); q++) begin
            enq_ready[q] = (cnt[q] != CW'(DEPTH));
            nonempty[q]  = (cnt[q] != '0);
            head_rec[q]  = mem[{QW'(q), rp[q]}];
            enq_fire[q]  = enq_valid[q] && enq_ready[q];
            pop_hit[q]   = pop_en && (pop_q == QW'(q));
        end
    end

    always_ff @(posedge clk) begin
        for (int q = 0; q < int'(NQ); q++) begin
            if (enq_fire[q]) begin
                mem[{QW'(q), wp[q]}] <= enq_rec[q];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < int'(NQ); q++) begin
                wp[q]  <= '0;
                rp[q]  <= '0;
                cnt[q] <= '0;
            end
        end else begin
            for (int q = 0; q < int'(NQ); q++) begin
                if (enq_fire[q]) wp[q] <= wp[q] + AW'(1);
                if (pop_hit[q])  rp[q] <= rp[q] + AW'(1);
                cnt[q] <= cnt[q] + CW'(enq_fire[q]) - CW'(pop_hit[q]);
            end
        end
    end

    for (genvar g = 0; g < int'(NQ); g++) begin : g_chk
        AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_en && pop_q == QW'(g)) |-> (cnt[g] != '0)); // R5
    end

endmodule

// File: rtl/mtl_out_queues.sv
module mtl_out_queues
    import mtl_pkg::*;
#(
    parameter int unsigned NQ    = 2,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned REC_W = 17,
    localparam int unsigned QW   = idx_w(NQ),
    localparam int unsigned AW   = idx_w(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [QW-1:0]              wr_q,
    input  logic [REC_W-1:0]           wr_rec,
    input  logic [NQ-1:0]              deq_ready,
    output logic [NQ-1:0][REC_W-1:0]   head_rec,
    output logic [NQ-1:0]              head_valid,
    input  logic                       take_en,
    input  logic [QW-1:0]              take_q,
    output logic [NQ-1:0]              has_credit
);

    localparam int unsigned SLOTS = 1 << (QW + AW);

    logic [REC_W-1:0] mem    [SLOTS];
    logic [AW-1:0]    wp     [NQ];
    logic [AW-1:0]    rp     [NQ];
    logic [CW-1:0]    cnt    [NQ];
    logic [CW-1:0]    credit [NQ];
    logic [NQ-1:0]    wr_hit;
    logic [NQ-1:0]    deq_fire;
    logic [NQ-1:0]    take_hit;

    always_comb begin
        for (int q = 0; q < int'(NQ); q++) begin
            head_valid[q] = (cnt[q] != '0);
            head_rec[q]   = mem[{QW'(q), rp[q]}];
            has_credit[q] = (credit[q] != '0);
            wr_hit[q]     = wr_en && (wr_q == QW'(q));
            take_hit[q]   = take_en && (take_q == QW'(q));
            deq_fire[q]   = head_valid[q] && deq_ready[q];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wr_q, wp[wr_q]}] <= wr_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < int'(NQ); q++) begin
                wp[q]     <= '0;
                rp[q]     <= '0;
                cnt[q]    <= '0;
                credit[q] <= CW'(DEPTH);
            end
        end else begin
            for (int q = 0; q < int'(NQ); q++) begin
                if (wr_hit[q])   wp[q] <= wp[q] + AW'(1);
                if (deq_fire[q]) rp[q] <= rp[q] + AW'(1);
                cnt[q]    <= cnt[q] + CW'(wr_hit[q]) - CW'(deq_fire[q]);
                credit[q] <= credit[q] - CW'(take_hit[q]) + CW'(deq_fire[q]);
            end
        end
    end

    for (genvar g = 0; g < int'(NQ); g++) begin : g_chk
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_q == QW'(g)) |-> (cnt[g] < CW'(DEPTH))); // R6
        AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            ({1'b0, credit[g]} + {1'b0, cnt[g]}) <= (CW + 1)'(DEPTH)); // R6
        AST_TAKE_WITH_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
            (take_en && take_q == QW'(g)) |-> (credit[g] != '0)); // R5
        AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (head_valid[g] && !deq_ready[g]) |=> (head_valid[g] && $stable(head_rec[g]))); // R8
    end

endmodule

// File: rtl/mtl_pair_sched.sv
module mtl_pair_sched
    import mtl_pkg::*;
#(
    parameter int unsigned NP = 2,
    localparam int unsigned PW = idx_w(NP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*NP-1:0]    nonempty,
    input  logic [NP-1:0]      has_credit,
    input  logic               done_en,
    input  logic [PW-1:0]      done_pair,
    input  logic               done_side,
    input  logic               done_last,
    output logic               grant_en,
    output logic [PW-1:0]      grant_pair,
    output run_state_e         run_st [NP]
);

    run_state_e    run_nx [NP];
    logic [NP-1:0] busy;
    logic [NP-1:0] elig;
    logic [PW-1:0] rr_last;

    // eligibility per pair, decided by its run state
    always_comb begin
        for (int p = 0; p < int'(NP); p++) begin
            elig[p] = 1'b0;
            unique case (run_st[p])
                RUN_MERGE:  elig[p] = nonempty[2*p] && nonempty[2*p+1];
                RUN_ONLY_A: elig[p] = nonempty[2*p];
                RUN_ONLY_B: elig[p] = nonempty[2*p+1];
                default:    elig[p] = 1'b0;
            endcase
            elig[p] = elig[p] && has_credit[p] && !busy[p];
        end
    end

    // round-robin pick, starting after the pair served last
    always_comb begin
        grant_en   = 1'b0;
        grant_pair = rr_last;
        for (int off = 1; off <= int'(NP); off++) begin
            int idx;
            idx = (int'(rr_last) + off) % int'(NP);
            if (!grant_en && elig[idx]) begin
                grant_en   = 1'b1;
                grant_pair = PW'(idx);
            end
        end
    end

    // run-state transitions on each pop
    always_comb begin
        for (int p = 0; p < int'(NP); p++) begin
            run_nx[p] = run_st[p];
            if (done_en && done_pair == PW'(p) && done_last) begin
                unique case (run_st[p])
                    RUN_MERGE:  run_nx[p] = done_side ? RUN_ONLY_A : RUN_ONLY_B;
                    RUN_ONLY_A: run_nx[p] = RUN_MERGE;
                    RUN_ONLY_B: run_nx[p] = RUN_MERGE;
                    default:    run_nx[p] = RUN_MERGE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < int'(NP); p++) run_st[p] <= RUN_MERGE;
            busy    <= '0;
            rr_last <= PW'(NP - 1);
        end else begin
            for (int p = 0; p < int'(NP); p++) begin
                run_st[p] <= run_nx[p];
                if (grant_en && grant_pair == PW'(p)) busy[p] <= 1'b1;
                else if (done_en && done_pair == PW'(p)) busy[p] <= 1'b0;
            end
            if (grant_en) rr_last <= grant_pair;
        end
    end

    AST_DONE_WAS_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        done_en |-> busy[done_pair]); // R9
    AST_ONLY_A_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_en && run_st[done_pair] == RUN_ONLY_A) |-> !done_side); // R4
    AST_ONLY_B_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_en && run_st[done_pair] == RUN_ONLY_B) |-> done_side); // R4

endmodule

// File: rtl/mtl_merge_level.sv
module mtl_merge_level
    import mtl_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 2,
    parameter int unsigned KEY_W     = 8,
    parameter int unsigned PAY_W     = 8,
    parameter int unsigned IN_DEPTH  = 4,
    parameter int unsigned OUT_DEPTH = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [2*NUM_PAIRS-1:0]          in_valid,
    output logic [2*NUM_PAIRS-1:0]          in_ready,
    input  logic [2*NUM_PAIRS-1:0]          in_last,
    input  logic [2*NUM_PAIRS*KEY_W-1:0]    in_key,
    input  logic [2*NUM_PAIRS*PAY_W-1:0]    in_pay,
    output logic [NUM_PAIRS-1:0]            out_valid,
    input  logic [NUM_PAIRS-1:0]            out_ready,
    output logic [NUM_PAIRS-1:0]            out_last,
    output logic [NUM_PAIRS*KEY_W-1:0]      out_key,
    output logic [NUM_PAIRS*PAY_W-1:0]      out_pay
);

    localparam int unsigned NS    = 2 * NUM_PAIRS;
    localparam int unsigned REC_W = 1 + KEY_W + PAY_W;
    localparam int unsigned PW    = idx_w(NUM_PAIRS);
    localparam int unsigned IQW   = idx_w(NS);

    logic [NS-1:0][REC_W-1:0]        iq_enq_rec;
    logic [NS-1:0][REC_W-1:0]        iq_head;
    logic [NS-1:0]                   iq_nonempty;
    logic [NUM_PAIRS-1:0][REC_W-1:0] oq_head;
    logic [NUM_PAIRS-1:0]            oq_credit;
    logic                            grant_en;
    logic [PW-1:0]                   grant_pair;
    run_state_e                      run_st [NUM_PAIRS];

    // pipeline registers
    logic             s1_vld, s2_vld, s3_vld;
    logic [PW-1:0]    s1_pair, s2_pair, s3_pair;
    logic [REC_W-1:0] s2_a, s2_b, s3_rec;
    run_state_e       s2_rs;

    // stage combinational results
    logic [REC_W-1:0] s1_head_a, s1_head_b, s2_sel;
    run_state_e       s1_rs;
    logic             s2_take_b, s2_sel_last, s2_out_last;
    logic [KEY_W-1:0] s2_key_a, s2_key_b;

    for (genvar s = 0; s < int'(NS); s++) begin : g_in
        assign iq_enq_rec[s] = {in_last[s], in_key[s*KEY_W +: KEY_W], in_pay[s*PAY_W +: PAY_W]};
    end

    for (genvar p = 0; p < int'(NUM_PAIRS); p++) begin : g_out
        assign out_last[p]                = oq_head[p][REC_W-1];
        assign out_key[p*KEY_W +: KEY_W]  = oq_head[p][PAY_W +: KEY_W];
        assign out_pay[p*PAY_W +: PAY_W]  = oq_head[p][PAY_W-1:0];
    end

    mtl_in_queues #(.NQ(NS), .DEPTH(IN_DEPTH), .REC_W(REC_W)) iq_i (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(in_valid), .enq_rec(iq_enq_rec), .enq_ready(in_ready),
        .pop_en(s2_vld), .pop_q(IQW'({s2_pair, s2_take_b})),
        .head_rec(iq_head), .nonempty(iq_nonempty)
    );

    mtl_pair_sched #(.NP(NUM_PAIRS)) sched_i (
        .clk(clk), .rst_n(rst_n),
        .nonempty(iq_nonempty), .has_credit(oq_credit),
        .done_en(s2_vld), .done_pair(s2_pair), .done_side(s2_take_b), .done_last(s2_sel_last),
        .grant_en(grant_en), .grant_pair(grant_pair), .run_st(run_st)
    );

    mtl_out_queues #(.NQ(NUM_PAIRS), .DEPTH(OUT_DEPTH), .REC_W(REC_W)) oq_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(s3_vld), .wr_q(s3_pair), .wr_rec(s3_rec),
        .deq_ready(out_ready), .head_rec(oq_head), .head_valid(out_valid),
        .take_en(grant_en), .take_q(grant_pair), .has_credit(oq_credit)
    );

    // stage 1: head read; stage 2: the shared compare
    always_comb begin
        s1_head_a   = iq_head[IQW'({s1_pair, 1'b0})];
        s1_head_b   = iq_head[IQW'({s1_pair, 1'b1})];
        s1_rs       = run_st[s1_pair];
        s2_key_a    = s2_a[PAY_W +: KEY_W];
        s2_key_b    = s2_b[PAY_W +: KEY_W];
        unique case (s2_rs)
            RUN_ONLY_A: s2_take_b = 1'b0;
            RUN_ONLY_B: s2_take_b = 1'b1;
            default:    s2_take_b = (s2_key_b < s2_key_a);
        endcase
        s2_sel      = s2_take_b ? s2_b : s2_a;
        s2_sel_last = s2_sel[REC_W-1];
        s2_out_last = s2_sel_last && (s2_rs != RUN_MERGE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s2_vld <= 1'b0;
            s3_vld <= 1'b0;
        end else begin
            s1_vld <= grant_en;
            s2_vld <= s1_vld;
            s3_vld <= s2_vld;
        end
    end

    always_ff @(posedge clk) begin
        s1_pair <= grant_pair;
        s2_pair <= s1_pair;
        s2_a    <= s1_head_a;
        s2_b    <= s1_head_b;
        s2_rs   <= s1_rs;
        s3_pair <= s2_pair;
        s3_rec  <= {s2_out_last, s2_sel[REC_W-2:0]};
    end

    // ascending-order checker state
    logic [KEY_W-1:0]     chk_prev_key [NUM_PAIRS];
    logic [NUM_PAIRS-1:0] chk_open;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_open <= '0;
            for (int p = 0; p < int'(NUM_PAIRS); p++) chk_prev_key[p] <= '0;
        end else if (s3_vld) begin
            chk_open[s3_pair]     <= !s3_rec[REC_W-1];
            chk_prev_key[s3_pair] <= s3_rec[PAY_W +: KEY_W];
        end
    end

    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_vld && chk_open[s3_pair]) |-> (s3_rec[PAY_W +: KEY_W] >= chk_prev_key[s3_pair])); // R2
    AST_PIPE_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s2_vld) |-> (s1_pair != s2_pair)); // R9

endmodule

// File: tb/mtl_merge_level_tb_top.sv
`timescale 1ns/100ps
module mtl_merge_level_tb_top;

    localparam int NP = 2;
    localparam int NS = 4;
    localparam int KW = 8;
    localparam int YW = 8;
    localparam int MAXL = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   in_valid = '0;
    logic [NS-1:0]   in_ready;
    logic [NS-1:0]   in_last = '0;
    logic [NS*KW-1:0] in_key = '0;
    logic [NS*YW-1:0] in_pay = '0;
    logic [NP-1:0]   out_valid;
    logic [NP-1:0]   out_ready = '0;
    logic [NP-1:0]   out_last;
    logic [NP*KW-1:0] out_key;
    logic [NP*YW-1:0] out_pay;

    always #2.5 clk = ~clk;

    mtl_merge_level dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
        .in_key(in_key), .in_pay(in_pay),
        .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
        .out_key(out_key), .out_pay(out_pay)
    );

    // entry: [13:11] phase, [10:9] stream, [8] end-of-run, [7:0] key
    localparam int NV = 43;
    localparam logic [13:0] VEC [NV] = '{
        {3'd0,2'd0,1'b0,8'd3},  {3'd0,2'd0,1'b0,8'd7},  {3'd0,2'd0,1'b1,8'd9},
        {3'd0,2'd1,1'b0,8'd2},  {3'd0,2'd1,1'b0,8'd8},  {3'd0,2'd1,1'b1,8'd20},
        {3'd0,2'd2,1'b0,8'd50}, {3'd0,2'd2,1'b1,8'd60},
        {3'd0,2'd3,1'b0,8'd10}, {3'd0,2'd3,1'b0,8'd55}, {3'd0,2'd3,1'b1,8'd70},
        {3'd1,2'd0,1'b0,8'd5},  {3'd1,2'd0,1'b1,8'd5},
        {3'd1,2'd1,1'b0,8'd5},  {3'd1,2'd1,1'b1,8'd5},
        {3'd1,2'd2,1'b1,8'd1},  {3'd1,2'd3,1'b1,8'd1},
        {3'd2,2'd0,1'b1,8'd1},  {3'd2,2'd0,1'b0,8'd2},  {3'd2,2'd0,1'b1,8'd3},
        {3'd2,2'd1,1'b0,8'd10}, {3'd2,2'd1,1'b1,8'd20}, {3'd2,2'd1,1'b1,8'd4},
        {3'd2,2'd2,1'b1,8'd30}, {3'd2,2'd3,1'b1,8'd31},
        {3'd3,2'd0,1'b0,8'd1},  {3'd3,2'd0,1'b0,8'd2},  {3'd3,2'd0,1'b0,8'd3},
        {3'd3,2'd0,1'b0,8'd4},  {3'd3,2'd0,1'b0,8'd5},  {3'd3,2'd0,1'b0,8'd6},
        {3'd3,2'd0,1'b0,8'd7},  {3'd3,2'd0,1'b1,8'd8},
        {3'd3,2'd1,1'b0,8'd11}, {3'd3,2'd1,1'b0,8'd12}, {3'd3,2'd1,1'b0,8'd13},
        {3'd3,2'd1,1'b0,8'd14}, {3'd3,2'd1,1'b0,8'd15}, {3'd3,2'd1,1'b0,8'd16},
        {3'd3,2'd1,1'b0,8'd17}, {3'd3,2'd1,1'b1,8'd18},
        {3'd4,2'd0,1'b1,8'd40}, {3'd4,2'd1,1'b1,8'd41}
    };

    int n_vec = 0;
    int n_bad = 0;
    logic [16:0] drv_mem [NS][MAXL];
    int          drv_len [NS];
    int          drv_idx [NS];
    logic [NS-1:0] fired;
    logic [16:0] exp_mem [NP][MAXL];
    int          exp_len [NP];
    int          got     [NP];
    logic [NP-1:0] stall_prev;
    logic [16:0] prev_rec [NP];
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, expv);
        end
    endtask

    task automatic build_exp(input int p);
        int ia, ib, la, lb;
        logic aend, bend, tb;
        logic [16:0] r;
        ia = 0; ib = 0; la = drv_len[2*p]; lb = drv_len[2*p+1];
        exp_len[p] = 0;
        while (ia < la || ib < lb) begin
            aend = 1'b0; bend = 1'b0;
            while (!(aend && bend)) begin
                if ((!aend && ia >= la) || (!bend && ib >= lb)) break;
                if (aend)      tb = 1'b1;
                else if (bend) tb = 1'b0;
                else           tb = (drv_mem[2*p+1][ib][15:8] < drv_mem[2*p][ia][15:8]);
                if (tb) begin r = drv_mem[2*p+1][ib]; ib++; if (r[16]) bend = 1'b1; end
                else    begin r = drv_mem[2*p][ia];   ia++; if (r[16]) aend = 1'b1; end
                exp_mem[p][exp_len[p]] = {aend && bend, r[15:0]};
                exp_len[p]++;
            end
            if (!(aend && bend)) break;
        end
    endtask

    task automatic step(input int ph, input string tag, input int cyc);
        logic [16:0] cur;
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        for (int s = 0; s < NS; s++) begin
            logic gate;
            if (fired[s]) drv_idx[s]++;
            gate = (ph == 3) ? 1'b1 : lfsr[s];
            if (ph == 4 && s == 1 && cyc < 30) gate = 1'b0;
            if (ph == 4) gate = gate | (s != 1);
            if (drv_idx[s] < drv_len[s] && gate) begin
                in_valid[s]          = 1'b1;
                in_last[s]           = drv_mem[s][drv_idx[s]][16];
                in_key[s*KW +: KW]   = drv_mem[s][drv_idx[s]][15:8];
                in_pay[s*YW +: YW]   = drv_mem[s][drv_idx[s]][7:0];
            end else begin
                in_valid[s] = 1'b0;
            end
            fired[s] = in_valid[s] && in_ready[s];
        end
        if (ph == 3 && cyc == 59) begin
            chk(in_ready[1:0] == 2'b00, "R6 in_ready under held out_ready", 32'(in_ready), 32'h0);
            chk(out_valid[0] == 1'b1, "R6 output queue holds records", 32'(out_valid[0]), 32'h1);
        end
        if (ph == 4 && cyc == 29)
            chk(out_valid[0] == 1'b0, "R5 pair waits for empty input", 32'(out_valid[0]), 32'h0);
        for (int p = 0; p < NP; p++) begin
            cur = {out_last[p], out_key[p*KW +: KW], out_pay[p*YW +: YW]};
            if (stall_prev[p])
                chk(out_valid[p] && cur == prev_rec[p], "R8 held output", 32'(cur), 32'(prev_rec[p]));
            if (ph == 3) out_ready[p] = (cyc >= 60);
            else         out_ready[p] = lfsr[8+p];
            if (out_valid[p] && out_ready[p]) begin
                if (got[p] >= exp_len[p]) begin
                    chk(1'b0, {tag, " extra output record"}, 32'(cur), 32'h0);
                end else begin
                    chk(cur[15:0] == exp_mem[p][got[p]][15:0], {tag, " record key/payload"},
                        32'(cur[15:0]), 32'(exp_mem[p][got[p]][15:0]));
                    chk(cur[16] == exp_mem[p][got[p]][16], "R2 end-of-run flag",
                        32'(cur[16]), 32'(exp_mem[p][got[p]][16]));
                end
                got[p]++;
            end
            stall_prev[p] = out_valid[p] && !out_ready[p];
            prev_rec[p]   = cur;
        end
    endtask

    task automatic run_phase(input int ph, input string tag);
        int cyc;
        logic done;
        for (int s = 0; s < NS; s++) begin drv_len[s] = 0; drv_idx[s] = 0; end
        fired = '0;
        stall_prev = '0;
        for (int i = 0; i < NV; i++) begin
            if (int'(VEC[i][13:11]) == ph) begin
                int s;
                s = int'(VEC[i][10:9]);
                drv_mem[s][drv_len[s]] = {VEC[i][8], VEC[i][7:0], 8'(i)};
                drv_len[s]++;
            end
        end
        for (int p = 0; p < NP; p++) begin build_exp(p); got[p] = 0; end
        cyc = 0;
        done = 1'b0;
        while (!done && cyc < 3000) begin
            step(ph, tag, cyc);
            cyc++;
            done = 1'b1;
            for (int p = 0; p < NP; p++) if (got[p] < exp_len[p]) done = 1'b0;
        end
        for (int p = 0; p < NP; p++)
            chk(got[p] == exp_len[p], {tag, " output record count"}, 32'(got[p]), 32'(exp_len[p]));
        @(negedge clk);
        in_valid = '0;
        out_ready = '0;
        repeat (10) @(negedge clk);
        chk(out_valid == '0, {tag, " no leftover output"}, 32'(out_valid), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(out_valid == '0, "R7 out_valid in reset", 32'(out_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == '0, "R7 out_valid after reset", 32'(out_valid), 32'h0);
        chk(in_ready == '1, "R7 in_ready after reset", 32'(in_ready), 32'hF);
        run_phase(0, "R1 R9");
        run_phase(1, "R3");
        run_phase(2, "R4");
        run_phase(3, "R6");
        run_phase(4, "R5");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule